// File: doc/BRIEF.md
# Receive Frame Statistics Unit

This unit keeps the receive-side counters of an Ethernet MAC. When a frame has been received, the receive path presents its length without FCS, its length with FCS and its address class, along with two control bits: long-frame enable and keep-bad-frames. It then pulses a one-cycle done strobe. In that same clock edge the unit decides whether the frame is too long. A too-long frame that is not being kept is reported as dropped and counted only in the oversize counter. Any other frame updates the packet, octet, class and size-histogram counters.

Every counter saturates at all-ones. Software reads counters through a small synchronous read port and clears them one at a time through a clear port. The two 64-bit octet counters are read as a low word and a high word. A read-port state machine has three states: `RD_IDLE`, `RD_TOT_HELD` and `RD_GOOD_HELD`.

- Reading a low word stores the matching high word in a latch and moves the machine to the HELD state for that counter.
- Reading that counter's high word while in its HELD state returns the latched value and goes back to `RD_IDLE`.
- Clearing the counter that is held also goes back to `RD_IDLE`.
- Any other access leaves the state as it is.

Top module: `rx_frame_stats`

## Requirements
- R1: After reset every counter reads zero and `drop_o` is low.
- R2: With long-frame enable low, a frame whose length without FCS is above 1518 is oversized and 1518 is not. An oversized frame with keep-bad-frames low raises `drop_o` in the cycle after the strobe. It adds one to the oversize counter (address 0) and changes no other counter.
- R3: With long-frame enable high, the oversize limit is 16380 bytes, so 16380 is accepted and 16381 is oversized.
- R4: With keep-bad-frames high, an oversized frame is not dropped. `drop_o` stays low, the oversize counter is unchanged and the frame is counted like any accepted frame.
- R5: Each accepted frame adds one to the total-frames counter (address 1) and to the good-frames counter (address 2).
- R6: Each accepted frame adds its length without FCS plus 4 to the total-octets counter (low/high words at addresses 11/12) and to the good-octets counter (13/14).
- R7: Class encoding is 0 for unicast, 1 for multicast, 2 for broadcast and 3 for unicast. An accepted broadcast frame adds one to address 3, an accepted multicast frame adds one to address 4, and unicast changes neither.
- R8: The histogram uses the length with FCS. Its bins are at addresses 5 to 10: exactly 64, 65-127, 128-255, 256-511, 512-1023, and 1024 and above. An accepted frame below 64 bytes changes no bin.
- R9: A counter at all-ones stays at all-ones on further increments and never wraps.
- R10: `rd_data` shows the addressed counter one cycle after `rd_en` and holds it while `rd_en` is low. Address 15 reads zero.
- R11: A read of an octet counter's high word that follows a read of its low word returns the high part as it was at the low read, even if frames arrived in between. A second high read returns the live value.
- R12: A clear (`clr_en`, `clr_addr`) zeroes one counter. Either word address clears a whole octet counter. A clear wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | One-cycle strobe: a frame has been received |
| frm_len | input | LEN_W | Frame length without FCS |
| frm_len_fcs | input | LEN_W | Frame length with FCS |
| frm_class | input | 2 | Address class (0 uni, 1 multi, 2 broad, 3 uni) |
| long_pkt_en | input | 1 | Raises the oversize limit to 16380 |
| store_bad_en | input | 1 | Keeps oversized frames instead of dropping |
| drop_o | output | 1 | Pulses the cycle after a dropped frame's strobe |
| clr_en | input | 1 | Clear strobe |
| clr_addr | input | 4 | Counter address to clear |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Counter address to read |
| rd_data | output | RD_W | Read data, registered |

## Verification
The hardest cases to reach are the top of each counter and the high-word latch. The bench uses a small configuration with 8-bit event counters, 16-bit octet counters and an 8-bit read port. Three hundred small frames then saturate the event counters, and a few long frames saturate the octet counters. The latch is tested by reading a low word, sending a frame that carries into the high byte, and then reading the high word twice. Clearing a held counter and a clear in the same cycle as a strobe are each driven as their own step.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BCAST = 2'd2,
        CLS_UNI2  = 2'd3
    } frm_class_e;

    typedef enum logic [1:0] {
        RD_IDLE      = 2'd0,
        RD_TOT_HELD  = 2'd1,
        RD_GOOD_HELD = 2'd2
    } rd_state_e;

    localparam int ADDR_W    = 4;
    localparam int NUM_BINS  = 6;
    localparam int NUM_SMALL = 5 + NUM_BINS;

    localparam logic [ADDR_W-1:0] A_OVS      = 4'd0;
    localparam logic [ADDR_W-1:0] A_TOT      = 4'd1;
    localparam logic [ADDR_W-1:0] A_GOOD     = 4'd2;
    localparam logic [ADDR_W-1:0] A_BCAST    = 4'd3;
    localparam logic [ADDR_W-1:0] A_MCAST    = 4'd4;
    localparam logic [ADDR_W-1:0] A_BIN0     = 4'd5;
    localparam logic [ADDR_W-1:0] A_TOCT_LO  = 4'd11;
    localparam logic [ADDR_W-1:0] A_TOCT_HI  = 4'd12;
    localparam logic [ADDR_W-1:0] A_GOCT_LO  = 4'd13;
    localparam logic [ADDR_W-1:0] A_GOCT_HI  = 4'd14;
endpackage

// File: rtl/rxst_sat_cnt.sv
module rxst_sat_cnt #(
    parameter int W  = 32,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc_en,
    input  logic [IW-1:0] inc_val,
    output logic [W-1:0]  cnt
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, cnt} + (W+1)'(inc_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc_en) begin
            cnt <= sum[W] ? '1 : sum[W-1:0];
        end
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt >= $past(cnt)));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (cnt == '1)) |=> (cnt == '1));
endmodule

// File: rtl/rxst_len_class.sv
module rxst_len_class #(
    parameter int LEN_W     = 16,
    parameter int SHORT_MAX = 1518,
    parameter int LONG_MAX  = 16380,
    parameter int NBINS     = 6
) (
    input  logic [LEN_W-1:0] frm_len,
    input  logic [LEN_W-1:0] frm_len_fcs,
    input  logic             long_en,
    output logic             is_over,
    output logic [NBINS-1:0] bin_hit
);
    localparam int FIRST_BIN = 64;

    logic [31:0] len_nofcs;
    logic [31:0] len_withfcs;
    logic [31:0] limit;

    always_comb begin
        len_nofcs   = 32'(frm_len);
        len_withfcs = 32'(frm_len_fcs);
        limit       = long_en ? 32'(LONG_MAX) : 32'(SHORT_MAX);
        is_over     = (len_nofcs > limit) || (len_nofcs > 32'(LONG_MAX));
    end

    // bin 0 is a single length; middle bins span (2^k .. 2^(k+1)-1) scaled
    // from the first bin; the top bin is open-ended
    for (genvar k = 0; k < NBINS; k++) begin : g_bin
        localparam int LO = (k == 0) ? FIRST_BIN :
                            (k == 1) ? FIRST_BIN + 1 : (FIRST_BIN / 2) << k;
        localparam int HI = (k == 0) ? FIRST_BIN : (FIRST_BIN << k) - 1;
        if (k == NBINS - 1) begin : g_top
            assign bin_hit[k] = (len_withfcs >= 32'(LO));
        end else begin : g_mid
            assign bin_hit[k] = (len_withfcs >= 32'(LO)) &&
                                (len_withfcs <= 32'(HI));
        end
    end
endmodule

// File: rtl/rxst_read_port.sv
module rxst_read_port
    import rxst_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OCT_W = 64,
    parameter int RD_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    input  logic                              clr_en,
    input  logic [ADDR_W-1:0]                 clr_addr,
    input  logic [NUM_SMALL-1:0][CNT_W-1:0]   small_cnt,
    input  logic [OCT_W-1:0]                  tot_oct,
    input  logic [OCT_W-1:0]                  good_oct,
    output logic [RD_W-1:0]                   rd_data
);
    localparam int EXT_W = 2 * RD_W;

    rd_state_e        st_q;
    rd_state_e        st_d;
    logic [RD_W-1:0]  hi_latch;
    logic [EXT_W-1:0] tot_ext;
    logic [EXT_W-1:0] good_ext;
    logic             lo_tot, lo_good, hi_tot, hi_good;
    logic             clr_tot, clr_good;
    logic [RD_W-1:0]  small_sel;

    always_comb begin
        tot_ext  = EXT_W'(tot_oct);
        good_ext = EXT_W'(good_oct);
        lo_tot   = rd_en && (rd_addr == A_TOCT_LO);
        hi_tot   = rd_en && (rd_addr == A_TOCT_HI);
        lo_good  = rd_en && (rd_addr == A_GOCT_LO);
        hi_good  = rd_en && (rd_addr == A_GOCT_HI);
        clr_tot  = clr_en && ((clr_addr == A_TOCT_LO) || (clr_addr == A_TOCT_HI));
        clr_good = clr_en && ((clr_addr == A_GOCT_LO) || (clr_addr == A_GOCT_HI));
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: begin
                if (lo_tot)       st_d = RD_TOT_HELD;
                else if (lo_good) st_d = RD_GOOD_HELD;
            end
            RD_TOT_HELD: begin
                if (lo_good)      st_d = RD_GOOD_HELD;
                else if (hi_tot)  st_d = RD_IDLE;
            end
            RD_GOOD_HELD: begin
                if (lo_tot)       st_d = RD_TOT_HELD;
                else if (hi_good) st_d = RD_IDLE;
            end
            default:              st_d = RD_IDLE;
        endcase
        if (clr_tot && (st_d == RD_TOT_HELD))   st_d = RD_IDLE;
        if (clr_good && (st_d == RD_GOOD_HELD)) st_d = RD_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        small_sel = '0;
        for (int i = 0; i < NUM_SMALL; i++) begin
            if (rd_addr == ADDR_W'(i)) small_sel = RD_W'(small_cnt[i]);
        end
    end

    // outputs: read data and high-word latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            hi_latch <= '0;
        end else begin
            if (lo_tot)  hi_latch <= tot_ext[EXT_W-1:RD_W];
            if (lo_good) hi_latch <= good_ext[EXT_W-1:RD_W];
            if (rd_en) begin
                if (lo_tot)
                    rd_data <= tot_ext[RD_W-1:0];
                else if (hi_tot)
                    rd_data <= (st_q == RD_TOT_HELD) ? hi_latch : tot_ext[EXT_W-1:RD_W];
                else if (lo_good)
                    rd_data <= good_ext[RD_W-1:0];
                else if (hi_good)
                    rd_data <= (st_q == RD_GOOD_HELD) ? hi_latch : good_ext[EXT_W-1:RD_W];
                else
                    rd_data <= small_sel;
            end
        end
    end

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_tot && !lo_good) |=> $stable(hi_latch));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R12
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tot |=> (st_q != RD_TOT_HELD));
endmodule

// File: rtl/rx_frame_stats.sv
module rx_frame_stats
    import rxst_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 32,
    parameter int OCT_W     = 64,
    parameter int RD_W      = 32,
    parameter int SHORT_MAX = 1518,
    parameter int LONG_MAX  = 16380
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_done,
    input  logic [LEN_W-1:0]     frm_len,
    input  logic [LEN_W-1:0]     frm_len_fcs,
    input  logic [1:0]           frm_class,
    input  logic                 long_pkt_en,
    input  logic                 store_bad_en,
    output logic                 drop_o,
    input  logic                 clr_en,
    input  logic [ADDR_W-1:0]    clr_addr,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [RD_W-1:0]      rd_data
);
    localparam int OIW     = LEN_W + 1;
    localparam int FCS_LEN = 4;

    logic                           is_over;
    logic [NUM_BINS-1:0]            bin_hit;
    logic                           drop_now;
    logic                           accept;
    logic [NUM_SMALL-1:0]           small_inc;
    logic [NUM_SMALL-1:0]           small_clr;
    logic [NUM_SMALL-1:0][CNT_W-1:0] small_cnt;
    logic [OIW-1:0]                 oct_add;
    logic [1:0][OCT_W-1:0]          oct_cnt;
    logic [1:0]                     oct_clr;
    frm_class_e                     cls;

    rxst_len_class #(
        .LEN_W(LEN_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX), .NBINS(NUM_BINS)
    ) len_class_i (
        .frm_len(frm_len), .frm_len_fcs(frm_len_fcs), .long_en(long_pkt_en),
        .is_over(is_over), .bin_hit(bin_hit)
    );

    always_comb begin
        cls      = frm_class_e'(frm_class);
        drop_now = frm_done && is_over && !store_bad_en;
        accept   = frm_done && !drop_now;
        oct_add  = OIW'(frm_len) + OIW'(FCS_LEN);
        small_inc = '0;
        small_inc[A_OVS]   = drop_now;
        small_inc[A_TOT]   = accept;
        small_inc[A_GOOD]  = accept;
        small_inc[A_BCAST] = accept && (cls == CLS_BCAST);
        small_inc[A_MCAST] = accept && (cls == CLS_MULTI);
        for (int b = 0; b < NUM_BINS; b++) begin
            small_inc[int'(A_BIN0) + b] = accept && bin_hit[b];
        end
        oct_clr[0] = clr_en && ((clr_addr == A_TOCT_LO) || (clr_addr == A_TOCT_HI));
        oct_clr[1] = clr_en && ((clr_addr == A_GOCT_LO) || (clr_addr == A_GOCT_HI));
    end

    for (genvar gi = 0; gi < NUM_SMALL; gi++) begin : g_small
        assign small_clr[gi] = clr_en && (clr_addr == ADDR_W'(gi));
        rxst_sat_cnt #(.W(CNT_W), .IW(1)) cnt_i (
            .clk(clk), .rst_n(rst_n), .clr(small_clr[gi]),
            .inc_en(small_inc[gi]), .inc_val(1'b1), .cnt(small_cnt[gi])
        );
    end

    for (genvar go = 0; go < 2; go++) begin : g_oct
        rxst_sat_cnt #(.W(OCT_W), .IW(OIW)) cnt_i (
            .clk(clk), .rst_n(rst_n), .clr(oct_clr[go]),
            .inc_en(accept), .inc_val(oct_add), .cnt(oct_cnt[go])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drop_o <= 1'b0;
        else        drop_o <= drop_now;
    end

    rxst_read_port #(.CNT_W(CNT_W), .OCT_W(OCT_W), .RD_W(RD_W)) read_port_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .clr_en(clr_en), .clr_addr(clr_addr), .small_cnt(small_cnt),
        .tot_oct(oct_cnt[0]), .good_oct(oct_cnt[1]), .rd_data(rd_data)
    );

    // R2
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> $past(frm_done));

    // R4
    keep_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && store_bad_en) |=> !drop_o);

    // R8
    bin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> $onehot0(bin_hit));

    // R5
    pair_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clr_en && (small_cnt[A_TOT] != '1)) |=> (small_cnt[A_TOT] != $past(small_cnt[A_TOT])));
endmodule

// File: tb/rx_frame_stats_tb_top.sv
module rx_frame_stats_tb_top;
    localparam int LEN_W = 15;
    localparam int CNT_W = 8;
    localparam int OCT_W = 16;
    localparam int RD_W  = 8;
    localparam int CMAX  = 255;
    localparam int OMAX  = 65535;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frm_done = 1'b0;
    logic [LEN_W-1:0] frm_len = '0;
    logic [LEN_W-1:0] frm_len_fcs = '0;
    logic [1:0]       frm_class = '0;
    logic             long_pkt_en = 1'b0;
    logic             store_bad_en = 1'b0;
    logic             drop_o;
    logic             clr_en = 1'b0;
    logic [3:0]       clr_addr = '0;
    logic             rd_en = 1'b0;
    logic [3:0]       rd_addr = '0;
    logic [RD_W-1:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_s[11];
    int exp_o[2];

    always #4 clk = ~clk;

    rx_frame_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .RD_W(RD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_len(frm_len),
        .frm_len_fcs(frm_len_fcs), .frm_class(frm_class), .long_pkt_en(long_pkt_en),
        .store_bad_en(store_bad_en), .drop_o(drop_o), .clr_en(clr_en),
        .clr_addr(clr_addr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int a);
        if (a == 0) return "R2 oversize";
        if (a <= 2) return "R5 frames";
        if (a <= 4) return "R7 class";
        return "R8 bin";
    endfunction

    task automatic inc_s(input int i);
        if (exp_s[i] < CMAX) exp_s[i]++;
    endtask

    task automatic model(input int len, input int cls, input bit lpe, input bit sbp,
                         output bit drop);
        int lim;
        int fcs;
        lim  = lpe ? 16380 : 1518;
        drop = (len > lim) && !sbp;
        fcs  = len + 4;
        if (drop) begin
            inc_s(0);
        end else begin
            inc_s(1); inc_s(2);
            if (cls == 2) inc_s(3);
            if (cls == 1) inc_s(4);
            if (fcs == 64) inc_s(5);
            else if (fcs >= 65 && fcs <= 127) inc_s(6);
            else if (fcs >= 128 && fcs <= 255) inc_s(7);
            else if (fcs >= 256 && fcs <= 511) inc_s(8);
            else if (fcs >= 512 && fcs <= 1023) inc_s(9);
            else if (fcs >= 1024) inc_s(10);
            for (int o = 0; o < 2; o++) begin
                exp_o[o] = (exp_o[o] + len + 4 > OMAX) ? OMAX : exp_o[o] + len + 4;
            end
        end
    endtask

    task automatic send(input int len, input int cls, input bit lpe, input bit sbp,
                        input string tag);
        bit d;
        @(negedge clk);
        frm_len = LEN_W'(len); frm_len_fcs = LEN_W'(len + 4);
        frm_class = 2'(cls); long_pkt_en = lpe; store_bad_en = sbp;
        frm_done = 1'b1;
        model(len, cls, lpe, sbp, d);
        @(negedge clk);
        frm_done = 1'b0;
        if (tag != "") chk({tag, " drop"}, int'(drop_o), int'(d));
    endtask

    task automatic do_read(input int a, output int v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic do_clear(input int a);
        @(negedge clk);
        clr_en = 1'b1; clr_addr = 4'(a);
        @(negedge clk);
        clr_en = 1'b0;
        if (a <= 10) exp_s[a] = 0;
        else if (a <= 12) exp_o[0] = 0;
        else if (a <= 14) exp_o[1] = 0;
    endtask

    task automatic clear_all();
        for (int a = 0; a <= 10; a++) do_clear(a);
        do_clear(11);
        do_clear(14);
    endtask

    task automatic check_all(input string over);
        int v;
        int h;
        for (int a = 0; a <= 10; a++) begin
            do_read(a, v);
            chk((over != "") ? over : tag_of(a), v, exp_s[a]);
        end
        for (int o = 0; o < 2; o++) begin
            do_read(11 + 2 * o, v);
            do_read(12 + 2 * o, h);
            chk((over != "") ? over : "R6 octets", h * 256 + v, exp_o[o]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        int v;
        for (int i = 0; i < 11; i++) exp_s[i] = 0;
        exp_o[0] = 0; exp_o[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drop after reset", int'(drop_o), 0);
        check_all("R1 reset value");
        do_read(15, v);
        chk("R10 unused address", v, 0);

        // class and length mix around the smallest bins
        for (int len = 56; len <= 70; len++) send(len, len % 4, 1'b0, 1'b0, "R5");
        check_all("");

        // oversize limit sweep over both control bits
        clear_all();
        for (int lpe = 0; lpe < 2; lpe++) begin
            for (int sbp = 0; sbp < 2; sbp++) begin
                foreach (exp_s[i]) ;
                send(1517, 0, lpe[0], sbp[0], sbp ? "R4" : (lpe ? "R3" : "R2"));
                send(1518, 1, lpe[0], sbp[0], sbp ? "R4" : (lpe ? "R3" : "R2"));
                send(1519, 2, lpe[0], sbp[0], sbp ? "R4" : (lpe ? "R3" : "R2"));
                send(16379, 0, lpe[0], sbp[0], sbp ? "R4" : (lpe ? "R3" : "R2"));
                send(16380, 2, lpe[0], sbp[0], sbp ? "R4" : (lpe ? "R3" : "R2"));
                send(16381, 1, lpe[0], sbp[0], sbp ? "R4" : (lpe ? "R3" : "R2"));
            end
        end
        check_all("");

        // histogram edges on length with FCS
        clear_all();
        send(59, 0, 1'b0, 1'b0, "R8");
        send(60, 0, 1'b0, 1'b0, "R8");
        send(61, 0, 1'b0, 1'b0, "R8");
        send(123, 0, 1'b0, 1'b0, "R8");
        send(124, 0, 1'b0, 1'b0, "R8");
        send(251, 0, 1'b0, 1'b0, "R8");
        send(252, 0, 1'b0, 1'b0, "R8");
        send(507, 0, 1'b0, 1'b0, "R8");
        send(508, 0, 1'b0, 1'b0, "R8");
        send(1019, 0, 1'b0, 1'b0, "R8");
        send(1020, 0, 1'b0, 1'b0, "R8");
        check_all("");

        // saturation of event and octet counters
        clear_all();
        for (int n = 0; n < 300; n++) send(60, 2, 1'b0, 1'b0, "");
        for (int n = 0; n < 5; n++) send(16000, 0, 1'b1, 1'b0, "");
        for (int n = 0; n < 3; n++) send(2000, 0, 1'b0, 1'b0, "R9");
        check_all("R9 saturation");

        // high-word latch
        clear_all();
        send(300, 0, 1'b0, 1'b0, "R6");
        do_read(11, v);
        chk("R11 low word", v, 8'h30);
        send(1000, 0, 1'b0, 1'b0, "R6");
        do_read(12, v);
        chk("R11 latched high word", v, 8'h01);
        do_read(12, v);
        chk("R11 live high word", v, 8'h05);
        @(negedge clk);
        chk("R10 data held", int'(rd_data), 8'h05);
        do_read(13, v);
        chk("R11 good low word", v, 8'h1C);
        do_clear(14);
        do_read(14, v);
        chk("R12 high after clear of held counter", v, 0);
        do_read(13, v);
        chk("R12 low after clear", v, 0);

        // clear wins over a same-cycle increment
        @(negedge clk);
        frm_len = LEN_W'(100); frm_len_fcs = LEN_W'(104);
        frm_class = 2'd0; long_pkt_en = 1'b0; store_bad_en = 1'b0;
        frm_done = 1'b1; clr_en = 1'b1; clr_addr = 4'd1;
        begin : mdl
            bit d;
            model(100, 0, 1'b0, 1'b0, d);
        end
        exp_s[1] = 0;
        @(negedge clk);
        frm_done = 1'b0; clr_en = 1'b0;
        do_read(1, v);
        chk("R12 clear beats increment", v, exp_s[1]);
        do_read(2, v);
        chk("R12 neighbour still counts", v, exp_s[2]);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule